// File: doc/BRIEF.md
# Addressed SPI Target on a Shared Select Line

This block is the target end of an SPI link on a bus where every target shares a single active-low select wire along with the serial clock, the controller-to-target data line and the target-to-controller data line. Since the select line does not pick out a target, each target carries a fixed address. The first word clocked in after select falls is that address. Every target on the bus hears it at the same moment.

Only the target whose address equals the first word turns on its return-data driver. It then exchanges the following words with the controller. Every other target keeps its driver off and ignores all clock and data activity until select falls again. The block runs on a fast system clock. The three bus inputs pass through a synchronizer, and bus edges are detected in the system clock domain. Received payload words appear on a one-cycle strobe. The user side can queue the next word to send. If nothing is queued, the target echoes the last word it received.

Top module: `addr_spi_target`

## Requirements
- R1: While reset is held and just after it is released, `miso_en_o` and `rx_valid_o` are low.
- R2: The first WORD_W bits clocked in after `csn_i` falls form the address word, and `miso_en_o` stays low throughout that word.
- R3: When the address word equals DEV_ADDR, `miso_en_o` goes high once that word is complete and stays high until `csn_i` rises, after which it is low.
- R4: When the address word differs from DEV_ADDR, `miso_en_o` stays low and no `rx_valid_o` pulse occurs until the next fall of `csn_i`, even if a later word equals DEV_ADDR.
- R5: Data moves most significant bit first in SPI mode 0. MOSI is sampled on the rising SCLK edge, and `miso_o` changes only after a falling SCLK edge, except that the first bit of each word is presented before that word's first rising edge.
- R6: A word captured by a `tx_load_i` pulse before a word boundary is the one sent in the word slot that follows that boundary. It stays queued across non-matching transactions until a matched boundary uses it.
- R7: If no word is queued at a word boundary of a matched transaction, the next slot returns the last word received. In the first payload slot, that is the address word.
- R8: Each complete payload word received while matched produces exactly one `rx_valid_o` pulse, one system-clock cycle wide, with `rx_data_o` holding the word.
- R9: If `csn_i` rises in the middle of a word, the partial word is discarded, the match is cleared, and the next transaction starts again with an address word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the controller |
| mosi_i | input | 1 | Serial data from the controller |
| csn_i | input | 1 | Shared active-low select |
| miso_o | output | 1 | Serial data to the controller (valid when enabled) |
| miso_en_o | output | 1 | Enable for the tri-state driver of the return line |
| tx_load_i | input | 1 | Strobe that queues `tx_data_i` for the next word slot |
| tx_data_i | input | WORD_W | Word to queue for sending |
| rx_valid_o | output | 1 | One-cycle strobe for a received payload word |
| rx_data_o | output | WORD_W | Last received payload word |

## Verification
The bench builds the block with WORD_W = 8, DEV_ADDR = 0xA6 and a two-stage synchronizer, with SCLK half-periods of eight system clocks. This leaves enough margin for sampling the return line just before each rising edge. It also lets the bench send addresses that differ from 0xA6 in only the lowest or only the highest bit, and a payload word equal to 0xA6 inside a non-matching transaction. Queued words carried across a non-matching transaction and a select release after three bits of a word are both covered with these values.

// File: rtl/ast_pkg.sv
package ast_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_DATA = 2'd2,
      ST_SKIP = 2'd3
   } ast_state_e;

   localparam int LN_SCLK = 0;
   localparam int LN_MOSI = 1;
   localparam int LN_CSN  = 2;
   localparam int LANES   = 3;
   localparam logic [LANES-1:0] LANE_IDLE = 3'b100;
endpackage

// File: rtl/ast_sync.sv
module ast_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   for (genvar b = 0; b < WIDTH; b++) begin : g_lane
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
         else        chain <= {chain[STAGES-2:0], async_i[b]};
      end
      assign sync_o[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/ast_edge.sv
module ast_edge #(
   parameter int               WIDTH   = 3,
   parameter logic [WIDTH-1:0] RST_VAL = '0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cur_i,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] fall_o
);
   logic [WIDTH-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= cur_i;
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_det
      assign rise_o[b] =  cur_i[b] & ~prev[b];
      assign fall_o[b] = ~cur_i[b] &  prev[b];
   end
endmodule

// File: rtl/ast_shifter.sv
module ast_shifter #(
   parameter int WORD_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              smp_i,
   input  logic              shf_i,
   input  logic              mosi_i,
   input  logic              tx_ld_i,
   input  logic [WORD_W-1:0] tx_val_i,
   output logic              byte_done_o,
   output logic [WORD_W-1:0] rx_word_o,
   output logic              tx_bit_o
);
   localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [CNT_W-1:0]  cnt;
   logic [WORD_W-1:0] rx_sh;
   logic [WORD_W-1:0] tx_sh;

   assign rx_word_o   = {rx_sh[WORD_W-2:0], mosi_i};
   assign byte_done_o = smp_i && (cnt == LAST);
   assign tx_bit_o    = tx_sh[WORD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         rx_sh <= '0;
      end else if (clr_i) begin
         cnt   <= '0;
         rx_sh <= '0;
      end else if (smp_i) begin
         rx_sh <= rx_word_o;
         cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end

   // the falling edge that closes a word keeps the freshly loaded MSB
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    tx_sh <= '0;
      else if (tx_ld_i)              tx_sh <= tx_val_i;
      else if (shf_i && cnt != '0)   tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
   end

   // R5
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!shf_i && !tx_ld_i) |=> $stable(tx_bit_o));
endmodule

// File: rtl/ast_ctrl.sv
module ast_ctrl import ast_pkg::*; #(
   parameter int                WORD_W   = 8,
   parameter logic [WORD_W-1:0] DEV_ADDR = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_rise_i,
   input  logic              sclk_fall_i,
   input  logic              cs_start_i,
   input  logic              cs_stop_i,
   input  logic              byte_done_i,
   input  logic [WORD_W-1:0] rx_word_i,
   input  logic              tx_load_i,
   input  logic [WORD_W-1:0] tx_data_i,
   output logic              smp_o,
   output logic              shf_o,
   output logic              clr_o,
   output logic              tx_ld_o,
   output logic [WORD_W-1:0] tx_val_o,
   output logic              miso_en_o,
   output logic              rx_valid_o,
   output logic [WORD_W-1:0] rx_data_o
);
   ast_state_e        state;
   logic              pend;
   logic [WORD_W-1:0] hold;
   logic              hit;

   assign hit       = (rx_word_i == DEV_ADDR);
   assign clr_o     = cs_start_i | cs_stop_i;
   assign smp_o     = sclk_rise_i && (state == ST_ADDR || state == ST_DATA);
   assign shf_o     = sclk_fall_i && (state == ST_DATA);
   assign tx_ld_o   = byte_done_i && ((state == ST_ADDR && hit) || state == ST_DATA);
   assign tx_val_o  = pend ? hold : rx_word_i;
   assign miso_en_o = (state == ST_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
      end else if (cs_stop_i) begin
         state <= ST_IDLE;
      end else if (cs_start_i) begin
         state <= ST_ADDR;
      end else if (byte_done_i && state == ST_ADDR) begin
         state <= hit ? ST_DATA : ST_SKIP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         hold <= '0;
      end else if (tx_load_i) begin
         pend <= 1'b1;
         hold <= tx_data_i;
      end else if (tx_ld_o) begin
         pend <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_valid_o <= 1'b0;
         rx_data_o  <= '0;
      end else begin
         rx_valid_o <= byte_done_i && (state == ST_DATA);
         if (byte_done_i && state == ST_DATA) rx_data_o <= rx_word_i;
      end
   end

   // R8
   rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o);
   // R4
   skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |=> !rx_valid_o);
   // R3
   match_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(miso_en_o) |-> $past(byte_done_i));
   // R9
   abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_stop_i |=> !miso_en_o);
endmodule

// File: rtl/addr_spi_target.sv
module addr_spi_target import ast_pkg::*; #(
   parameter int                WORD_W      = 8,
   parameter logic [WORD_W-1:0] DEV_ADDR    = WORD_W'('hA6),
   parameter int                SYNC_STAGES = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              mosi_i,
   input  logic              csn_i,
   output logic              miso_o,
   output logic              miso_en_o,
   input  logic              tx_load_i,
   input  logic [WORD_W-1:0] tx_data_i,
   output logic              rx_valid_o,
   output logic [WORD_W-1:0] rx_data_o
);
   if (WORD_W < 2) begin : g_bad_width
      $error("addr_spi_target: WORD_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("addr_spi_target: SYNC_STAGES must be at least 2");
   end

   logic [LANES-1:0]  lane_raw, lane_s, lane_rise, lane_fall;
   logic              smp, shf, clr, tx_ld, byte_done, tx_bit, en;
   logic [WORD_W-1:0] tx_val, rx_word;

   assign lane_raw[LN_SCLK] = sclk_i;
   assign lane_raw[LN_MOSI] = mosi_i;
   assign lane_raw[LN_CSN]  = csn_i;

   ast_sync #(.WIDTH(LANES), .STAGES(SYNC_STAGES), .RST_VAL(LANE_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(lane_raw), .sync_o(lane_s));

   ast_edge #(.WIDTH(LANES), .RST_VAL(LANE_IDLE)) u_edge (
      .clk(clk), .rst_n(rst_n), .cur_i(lane_s), .rise_o(lane_rise), .fall_o(lane_fall));

   ast_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .smp_i(smp), .shf_i(shf),
      .mosi_i(lane_s[LN_MOSI]), .tx_ld_i(tx_ld), .tx_val_i(tx_val),
      .byte_done_o(byte_done), .rx_word_o(rx_word), .tx_bit_o(tx_bit));

   ast_ctrl #(.WORD_W(WORD_W), .DEV_ADDR(DEV_ADDR)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .sclk_rise_i(lane_rise[LN_SCLK]), .sclk_fall_i(lane_fall[LN_SCLK]),
      .cs_start_i(lane_fall[LN_CSN]), .cs_stop_i(lane_rise[LN_CSN]),
      .byte_done_i(byte_done), .rx_word_i(rx_word),
      .tx_load_i(tx_load_i), .tx_data_i(tx_data_i),
      .smp_o(smp), .shf_o(shf), .clr_o(clr), .tx_ld_o(tx_ld), .tx_val_o(tx_val),
      .miso_en_o(en), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o));

   assign miso_en_o = en;
   assign miso_o    = en & tx_bit;
endmodule

// File: tb/addr_spi_target_bench.sv
module addr_spi_target_bench;
   localparam int          HALF = 8;
   localparam logic [7:0]  DEV  = 8'hA6;
   // {load_en, load_val, addr, d0, d1}
   localparam logic [32:0] VEC [6] = '{
      {1'b0, 8'h00, 8'hA6, 8'h3C, 8'h81},
      {1'b1, 8'h5F, 8'hA6, 8'h00, 8'hFF},
      {1'b0, 8'h00, 8'hA7, 8'hA6, 8'h12},
      {1'b1, 8'h99, 8'h26, 8'hA6, 8'hA6},
      {1'b0, 8'h00, 8'hA6, 8'hE1, 8'h7E},
      {1'b1, 8'h00, 8'hA6, 8'h55, 8'hAA}
   };

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       sclk = 1'b0, mosi = 1'b0, csn = 1'b1, tx_load = 1'b0;
   logic [7:0] tx_data = '0;
   logic       miso, miso_en, rx_valid;
   logic [7:0] rx_data;

   int checks = 0, errors = 0, vcnt = 0, dbl = 0;
   logic [7:0] vlast = '0;
   logic vprev = 1'b0, done = 1'b0;

   addr_spi_target #(.WORD_W(8), .DEV_ADDR(DEV), .SYNC_STAGES(2)) u_addr_spi_target (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .mosi_i(mosi), .csn_i(csn),
      .miso_o(miso), .miso_en_o(miso_en), .tx_load_i(tx_load), .tx_data_i(tx_data),
      .rx_valid_o(rx_valid), .rx_data_o(rx_data));

   always #2 clk = ~clk;

   always @(negedge clk) begin
      if (rx_valid) begin
         vcnt++;
         vlast = rx_data;
         if (vprev) dbl++;
      end
      vprev = rx_valid;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic xbyte(input logic [7:0] tx, input int nbits,
                        output logic [7:0] rx, output int en_cnt);
      rx = '0;
      en_cnt = 0;
      for (int i = 0; i < nbits; i++) begin
         mosi = tx[7-i];
         repeat (HALF) @(negedge clk);
         rx[7-i] = miso;
         if (miso_en) en_cnt++;
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
   endtask

   task automatic cs_on();
      csn = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic cs_off();
      repeat (HALF) @(negedge clk);
      csn = 1'b1;
      repeat (2*HALF) @(negedge clk);
   endtask

   task automatic queue(input logic [7:0] v);
      @(negedge clk);
      tx_data = v;
      tx_load = 1'b1;
      @(negedge clk);
      tx_load = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic       pend;
      logic [7:0] pval, r0, r1, r2, exp0;
      int         e0, e1, e2, v0;
      pend = 1'b0;
      pval = '0;

      repeat (3) @(negedge clk);
      check("R1 enable in reset", 32'(miso_en), 0);
      check("R1 valid in reset", 32'(rx_valid), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R1 enable after reset", 32'(miso_en), 0);
      check("R1 valid after reset", 32'(rx_valid), 0);

      for (int v = 0; v < 6; v++) begin
         logic ld, match;
         logic [7:0] lv, ad, d0, d1;
         {ld, lv, ad, d0, d1} = VEC[v];
         match = (ad == DEV);
         if (ld) begin
            queue(lv);
            pend = 1'b1;
            pval = lv;
         end
         v0 = vcnt;
         cs_on();
         xbyte(ad, 8, r0, e0);
         xbyte(d0, 8, r1, e1);
         xbyte(d1, 8, r2, e2);
         cs_off();
         check("R2 enable during address", 32'(e0), 0);
         if (match) begin
            exp0 = pend ? pval : ad;
            pend = 1'b0;
            check("R3 enable in payload", 32'(e1 + e2), 16);
            check("R5 R6 R7 first reply", 32'(r1), 32'(exp0));
            check("R5 R7 echo reply", 32'(r2), 32'(d0));
            check("R8 valid count", 32'(vcnt - v0), 2);
            check("R8 last word", 32'(vlast), 32'(d1));
         end else begin
            check("R4 enable stays low", 32'(e1 + e2), 0);
            check("R4 no valid", 32'(vcnt - v0), 0);
         end
         check("R3 released at end", 32'(miso_en), 0);
      end

      // mid-word select release
      v0 = vcnt;
      cs_on();
      xbyte(DEV, 8, r0, e0);
      xbyte(8'hFF, 3, r1, e1);
      cs_off();
      check("R9 enable after abort", 32'(miso_en), 0);
      check("R9 no valid from partial", 32'(vcnt - v0), 0);
      cs_on();
      xbyte(DEV, 8, r0, e0);
      check("R9 address again after abort", 32'(e0), 0);
      xbyte(8'h5A, 8, r1, e1);
      cs_off();
      check("R7 R9 echo after abort", 32'(r1), 32'(DEV));
      check("R9 one valid", 32'(vcnt - v0), 1);
      check("R9 clean word", 32'(vlast), 32'h5A);
      check("R8 single-cycle pulses", 32'(dbl), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule